// File: doc/BRIEF.md
# Scan-Sampled Push-Button Debouncer with Change Pulse

This block cleans the level of a mechanical push-button that bounces when it is pressed and when it is let go. The raw pin is first brought into the system clock domain by a short synchronizer chain. It is then captured only on a slow, periodic scan strobe, never on every clock. Bounce that settles in less than one scan period therefore reaches the output as a single transition, and this holds for the release edge as well as for the press edge.

A second capture register takes the first register's value on the following scan strobe. While the two registers disagree, the block drives a change pulse. That pulse is high for exactly one scan period after every press and after every release. One button can therefore step two clock phases: one phase on the press and the other on the release. The scan period is a parameter given in system clock cycles, so scan rates of about 50 Hz, 100 Hz or 150 Hz are set at instantiation. A second parameter selects which raw pin level means "pressed". Both outputs are normalised so that 1 means pressed.

Top module: `button_debounce_pulser`

## Requirements
- R1: During reset and after it ends, with the raw input held at its released level, `level_o` is 0 and `pulse_o` is 0.
- R2: `level_o` and `pulse_o` change only on the clock edge that ends a scan period. Counting clock edges after reset release from 1, these are the edges whose index is a multiple of `CLKS_PER_SCAN`. Raw changes between such edges have no effect on the outputs until the next such edge.
- R3: A clean change of the raw input appears on `level_o` no more than `CLKS_PER_SCAN + SYNC_STAGES` clock edges after it is applied.
- R4: A press whose bounce lasts less than one scan period gives exactly one 0-to-1 transition of `level_o` and exactly one change pulse.
- R5: A release whose bounce lasts less than one scan period gives exactly one 1-to-0 transition of `level_o` and exactly one change pulse. No extra pulse appears.
- R6: Each change pulse from an isolated edge is high for exactly `CLKS_PER_SCAN` clock cycles.
- R7: `pulse_o` is high whenever the current sample differs from the previous one. If a press is sampled on one scan edge and the release on the next, the pulse stays high without a gap for 2×`CLKS_PER_SCAN` cycles, and `level_o` returns to 0.
- R8: With `PRESSED_LEVEL` = 0, an inverted raw input gives the same `level_o` and `pulse_o` as the active-high variant driven by the true level.
- R9: The internal scan strobe is one clock wide and recurs exactly every `CLKS_PER_SCAN` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw, asynchronous, bouncy button level |
| level_o | output | 1 | Debounced level, 1 = pressed |
| pulse_o | output | 1 | Change pulse, one scan period wide per press or release |

## Verification
Two functions can land on the same scan edge: the first register captures a new button level while the change pulse from the previous level ends. The bench provokes this with a tap. It waits until `level_o` rises and then releases the button at once, so the release is captured on the very next scan edge. It then checks that the pulse runs for two full scan periods without a gap, that the level has toggled twice and that only one pulse was counted. In every test a monitor also checks that level changes occur only on scan-boundary edges.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

   // Counter width for a terminal count n (at least one bit).
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   typedef struct packed {
      logic cur;
      logic prev;
   } sample_pair_t;

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbnc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbnc_scan_tick.sv
module dbnc_scan_tick #(
   parameter int CLKS_PER_SCAN = 1_000_000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int W = dbnc_pkg::cnt_width(CLKS_PER_SCAN);
   localparam logic [W-1:0] LAST = W'(CLKS_PER_SCAN - 1);

   generate
      if (CLKS_PER_SCAN < 2) begin : g_bad_period
         $error("dbnc_scan_tick: CLKS_PER_SCAN must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);
endmodule

// File: rtl/dbnc_sample_pair.sv
module dbnc_sample_pair (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic d,
   output logic level,
   output logic pulse
);
   dbnc_pkg::sample_pair_t st;

   always_ff @(posedge clk) begin
      if (rst) begin
         st <= '0;
      end else if (tick) begin
         st.cur  <= d;
         st.prev <= st.cur;
      end
   end

   assign level = st.cur;
   assign pulse = st.cur ^ st.prev;
endmodule

// File: rtl/button_debounce_pulser.sv
module button_debounce_pulser #(
   parameter int CLKS_PER_SCAN = 1_000_000,
   parameter int SYNC_STAGES   = 2,
   parameter bit PRESSED_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_raw,
   output logic level_o,
   output logic pulse_o
);
   localparam bit RELEASED_LEVEL = ~PRESSED_LEVEL;

   logic btn_sync;
   logic btn_norm;
   logic scan_tick;

   dbnc_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(RELEASED_LEVEL)
   ) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (btn_raw),
      .q  (btn_sync)
   );

   generate
      if (PRESSED_LEVEL) begin : g_active_high
         assign btn_norm = btn_sync;
      end else begin : g_active_low
         assign btn_norm = ~btn_sync;
      end
   endgenerate

   dbnc_scan_tick #(
      .CLKS_PER_SCAN(CLKS_PER_SCAN)
   ) u_tick (
      .clk (clk),
      .rst (rst),
      .tick(scan_tick)
   );

   dbnc_sample_pair u_pair (
      .clk  (clk),
      .rst  (rst),
      .tick (scan_tick),
      .d    (btn_norm),
      .level(level_o),
      .pulse(pulse_o)
   );
endmodule

// File: rtl/dbnc_checker.sv
module dbnc_checker #(
   parameter int CLKS_PER_SCAN = 1_000_000
) (
   input logic clk,
   input logic rst,
   input logic tick,
   input logic level,
   input logic pulse
);
   int unsigned gap;

   always_ff @(posedge clk) begin
      if (rst)       gap <= 0;
      else if (tick) gap <= 0;
      else           gap <= gap + 1;
   end

   // R9: strobe spacing
   assert_tick_period_R9: assert property (@(posedge clk) disable iff (rst)
      tick |-> (gap == CLKS_PER_SCAN - 1));

   // R9: strobe is a single cycle
   assert_tick_single_R9: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   // R1: idle outputs right after reset
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!level && !pulse));

   // R2: outputs move only on a scan edge
   assert_level_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(tick) |-> ($stable(level) && $stable(pulse)));

   // R7: any level change is accompanied by the change pulse
   assert_change_pulses_R7: assert property (@(posedge clk) disable iff (rst)
      !$stable(level) |-> pulse);
endmodule

bind button_debounce_pulser dbnc_checker #(
   .CLKS_PER_SCAN(CLKS_PER_SCAN)
) u_chk (
   .clk  (clk),
   .rst  (rst),
   .tick (scan_tick),
   .level(level_o),
   .pulse(pulse_o)
);

// File: tb/tb_button_debounce_pulser.sv
module tb_button_debounce_pulser;
   localparam int N    = 16;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic btn = 1'b0;
   logic btn_n;
   logic level_o, pulse_o, level_n, pulse_n;

   assign btn_n = ~btn;

   always #5 clk = ~clk;

   button_debounce_pulser #(.CLKS_PER_SCAN(N), .SYNC_STAGES(SYNC), .PRESSED_LEVEL(1'b1)) dut (
      .clk(clk), .rst(rst), .btn_raw(btn), .level_o(level_o), .pulse_o(pulse_o));

   button_debounce_pulser #(.CLKS_PER_SCAN(N), .SYNC_STAGES(SYNC), .PRESSED_LEVEL(1'b0)) dut_n (
      .clk(clk), .rst(rst), .btn_raw(btn_n), .level_o(level_n), .pulse_o(pulse_n));

   int total = 0;
   int bad   = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: edge index, pulse runs, level transitions, phase and variant agreement
   int edge_idx = 0;
   int pulse_cnt = 0, run = 0, last_w = 0, lvl_chg = 0;
   int phase_err = 0, var_err = 0;
   logic prev_lvl = 1'b0, prev_pls = 1'b0;

   always @(posedge clk) if (!rst) edge_idx++;

   always @(negedge clk) begin
      if (!rst) begin
         if (pulse_o && !prev_pls) begin pulse_cnt++; run = 1; end
         else if (pulse_o)          run++;
         if (!pulse_o && prev_pls)  last_w = run;
         if (level_o != prev_lvl) begin
            lvl_chg++;
            if (edge_idx % N != 0) phase_err++;  // R2
         end
         if (level_n != level_o || pulse_n != pulse_o) var_err++;  // R8
      end
      prev_lvl = level_o;
      prev_pls = pulse_o;
   end

   task automatic wait_level(input logic v, output int edges);
      edges = 0;
      while (level_o !== v && edges < 4 * N) begin
         @(negedge clk);
         edges++;
      end
   endtask

   task automatic t_reset_idle();
      check(level_o == 1'b0, "R1 level after reset", level_o, 0);
      check(pulse_o == 1'b0, "R1 pulse after reset", pulse_o, 0);
      repeat (5 * N) @(negedge clk);
      check(pulse_cnt == 0, "R1 no pulse while idle", pulse_cnt, 0);
      check(level_o == 1'b0, "R1 level stays idle", level_o, 0);
   endtask

   task automatic t_clean_edges();
      int e;
      repeat (3) @(negedge clk);
      btn = 1'b1;
      wait_level(1'b1, e);
      check(e <= N + SYNC, "R3 press latency", e, N + SYNC);
      repeat (3 * N) @(negedge clk);
      check(last_w == N, "R6 press pulse width", last_w, N);
      btn = 1'b0;
      wait_level(1'b0, e);
      check(e <= N + SYNC, "R3 release latency", e, N + SYNC);
      repeat (3 * N) @(negedge clk);
      check(last_w == N, "R6 release pulse width", last_w, N);
   endtask

   task automatic bounce_to(input logic final_v);
      for (int i = 0; i < N - 4; i++) begin
         btn = ((i * 7 + 3) % 5 < 2) ? ~final_v : final_v;
         @(negedge clk);
      end
      btn = final_v;
   endtask

   task automatic t_bouncy_press();
      int p0 = pulse_cnt, c0 = lvl_chg;
      repeat (5) @(negedge clk);
      bounce_to(1'b1);
      repeat (4 * N) @(negedge clk);
      check(pulse_cnt - p0 == 1, "R4 one pulse on bouncy press", pulse_cnt - p0, 1);
      check(lvl_chg - c0 == 1, "R4 one transition on bouncy press", lvl_chg - c0, 1);
      check(level_o == 1'b1, "R4 level pressed", level_o, 1);
      check(last_w == N, "R6 bouncy press pulse width", last_w, N);
   endtask

   task automatic t_bouncy_release();
      int p0 = pulse_cnt, c0 = lvl_chg;
      repeat (7) @(negedge clk);
      bounce_to(1'b0);
      repeat (4 * N) @(negedge clk);
      check(pulse_cnt - p0 == 1, "R5 one pulse on bouncy release", pulse_cnt - p0, 1);
      check(lvl_chg - c0 == 1, "R5 one transition on bouncy release", lvl_chg - c0, 1);
      check(level_o == 1'b0, "R5 level released", level_o, 0);
   endtask

   task automatic t_tap();
      int e;
      int p0 = pulse_cnt, c0 = lvl_chg;
      btn = 1'b1;
      wait_level(1'b1, e);
      btn = 1'b0;  // captured on the very next scan edge
      repeat (4 * N) @(negedge clk);
      check(last_w == 2 * N, "R7 merged pulse width", last_w, 2 * N);
      check(pulse_cnt - p0 == 1, "R7 single merged pulse", pulse_cnt - p0, 1);
      check(lvl_chg - c0 == 2, "R7 level toggled twice", lvl_chg - c0, 2);
      check(level_o == 1'b0, "R7 level back to released", level_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_idle();
      t_clean_edges();
      t_bouncy_press();
      t_bouncy_release();
      t_tap();
      check(phase_err == 0, "R2 level changes only on scan-boundary edges", phase_err, 0);
      check(var_err == 0, "R8 active-low variant matches", var_err, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule